// File: doc/BRIEF.md
# SPI Burst Register-Access Slave

This block sits behind an SPI mode-0 slave port and turns each chip-select frame into a burst of accesses on a 32-bit internal register bus. The master first sends a 32-bit command word carrying an operation code, a byte address and a word count. It then sends or receives as many 32-bit data words as that count says. Every data word becomes one bus access, and the address steps by four bytes from one word to the next.

The serial pins are sampled by the system clock. SCLK must therefore be slow enough that each SPI half-period spans several system clocks. While a command word is arriving, the slave returns a status byte supplied by the surrounding logic.

Two error cases are flagged. A command that cannot be run raises a command flag for the rest of the frame. A frame whose clock count disagrees with its word count raises a sticky framing flag, which stays set until reset.

Top module: `spi_burst_slave`

## Requirements
- R1: After reset, `spi_miso_oe`, `spi_miso`, `bus_req`, `frame_err` and `cmd_err` are all low.
- R2: While `spi_cs_n` is high, `spi_miso_oe` and `spi_miso` are low. While it is low, `spi_miso_oe` is high.
- R3: The command word is sampled on rising SCLK edges, MSB first. Bits 31:24 hold the code (0x61 = write, 0x41 = read), bits 23:8 hold the byte address and bits 7:0 hold the word count.
- R4: During the 32 command bits, MISO returns `status_byte` (MSB first, captured when chip select falls) followed by 24 zero bits.
- R5: In a write frame, each fully received data word k (k = 1..count) produces exactly one bus write of that word to address A + 4(k-1), where A is the command address.
- R6: In a read frame, data word k is returned on MISO MSB first and equals the bus read of address A + 4(k-1). Exactly `count` bus reads are issued.
- R7: Once `bus_req` rises, it stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until the cycle in which `bus_ack` is high.
- R8: A command code other than 0x41 or 0x61, or a count of zero, raises `cmd_err`. The rest of that frame then issues no bus access and MISO stays low.
- R9: `frame_err` is set when chip select rises before the command word is complete, or when a valid command's frame did not last exactly 32 + 32·count SCLK cycles. A partial data word is never written, and no word beyond the count is written.
- R10: `cmd_err` clears when the next frame starts. `frame_err` stays high until reset, including across later correct frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| status_byte | input | 8 | Status returned during the command word |
| bus_req | output | 1 | Bus access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Byte address of the access |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | One-cycle completion strobe |
| frame_err | output | 1 | Sticky framing error |
| cmd_err | output | 1 | Current frame carries an unusable command |

## Verification
The hardest case is a read burst. There, the fetch for the next word has to finish in the short gap between the last rising edge of one word and the first sampling point of the next. The bench's bus model adds several cycles of acknowledge latency, so this gap is really exercised. The returned words are then compared bit by bit against the model memory.

The framing cases are reached by ending chip select mid-word, past the count, and inside the command word. The write count and memory contents are then inspected to show that partial and surplus words had no effect.

// File: rtl/spi_burst_slave.sv
module spi_burst_slave #(
  parameter int          ADDR_W = 16,
  parameter int          LEN_W  = 8,
  parameter int          STAT_W = 8,
  parameter logic [7:0]  RD_OP  = 8'h41,
  parameter logic [7:0]  WR_OP  = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [STAT_W-1:0] status_byte,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack,
  output logic              frame_err,
  output logic              cmd_err
);
  localparam int WORD_W = 32;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int WC_W   = LEN_W + 1;
  localparam int OP_W   = WORD_W - ADDR_W - LEN_W;

  logic sclk_q, sclk_p, cs_q, cs_p, mosi_q;
  logic [BIT_W-1:0]  bit_cnt;
  logic [WC_W-1:0]   word_cnt;
  logic [WORD_W-1:0] rx_sr, tx_sr;
  logic              skip_fall, is_rd, is_wr;
  logic [LEN_W-1:0]  len_r;
  logic [ADDR_W-1:0] cur_addr;

  wire active    = ~cs_q;
  wire sclk_rise = sclk_q & ~sclk_p;
  wire sclk_fall = ~sclk_q & sclk_p;
  wire cs_fall   = ~cs_q & cs_p;
  wire cs_rise   = cs_q & ~cs_p;
  wire word_end  = active & sclk_rise & (bit_cnt == BIT_W'(WORD_W - 1));

  wire [WORD_W-1:0] rx_word  = {rx_sr[WORD_W-2:0], mosi_q};
  wire [OP_W-1:0]   hdr_op   = rx_word[WORD_W-1 -: OP_W];
  wire [ADDR_W-1:0] hdr_addr = rx_word[LEN_W +: ADDR_W];
  wire [LEN_W-1:0]  hdr_len  = rx_word[LEN_W-1:0];
  wire              hdr_ok   = ((hdr_op == RD_OP) || (hdr_op == WR_OP)) && (hdr_len != '0);
  wire [WC_W-1:0]   want_cnt = WC_W'(len_r) + WC_W'(1);
  wire              cnt_bad  = (word_cnt == '0) ||
                               ((is_rd || is_wr) && !((bit_cnt == '0) && (word_cnt == want_cnt)));

  assign spi_miso_oe = active;
  assign spi_miso    = active & tx_sr[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      sclk_p    <= 1'b0;
      cs_q      <= 1'b1;
      cs_p      <= 1'b1;
      mosi_q    <= 1'b0;
      bit_cnt   <= '0;
      word_cnt  <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      skip_fall <= 1'b0;
      is_rd     <= 1'b0;
      is_wr     <= 1'b0;
      len_r     <= '0;
      cur_addr  <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      frame_err <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      sclk_q <= spi_sclk;
      sclk_p <= sclk_q;
      cs_q   <= spi_cs_n;
      cs_p   <= cs_q;
      mosi_q <= spi_mosi;

      if (cs_fall) begin
        bit_cnt   <= '0;
        word_cnt  <= '0;
        rx_sr     <= '0;
        tx_sr     <= {status_byte, {(WORD_W-STAT_W){1'b0}}};
        skip_fall <= 1'b0;
        is_rd     <= 1'b0;
        is_wr     <= 1'b0;
        cmd_err   <= 1'b0;
      end else if (active && sclk_rise) begin
        rx_sr   <= rx_word;
        bit_cnt <= bit_cnt + BIT_W'(1);
        if (word_end) begin
          if (word_cnt != '1) word_cnt <= word_cnt + WC_W'(1);
          skip_fall <= 1'b1;
          tx_sr     <= '0;
          if (word_cnt == '0) begin
            if (hdr_ok) begin
              is_rd    <= (hdr_op == RD_OP);
              is_wr    <= (hdr_op == WR_OP);
              len_r    <= hdr_len;
              cur_addr <= hdr_addr;
              if (hdr_op == RD_OP) begin
                bus_req  <= 1'b1;
                bus_we   <= 1'b0;
                bus_addr <= hdr_addr;
              end
            end else begin
              cmd_err <= 1'b1;
            end
          end else if (is_wr && (word_cnt <= WC_W'(len_r))) begin
            bus_req   <= 1'b1;
            bus_we    <= 1'b1;
            bus_addr  <= cur_addr;
            bus_wdata <= rx_word;
          end else if (is_rd && (word_cnt < WC_W'(len_r))) begin
            bus_req  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= cur_addr;
          end
        end
      end else if (active && sclk_fall) begin
        if (skip_fall) skip_fall <= 1'b0;
        else           tx_sr     <= {tx_sr[WORD_W-2:0], 1'b0};
      end

      if (cs_rise && cnt_bad) frame_err <= 1'b1;

      if (bus_req && bus_ack) begin
        bus_req  <= 1'b0;
        cur_addr <= cur_addr + ADDR_W'(4);
        if (!bus_we) tx_sr <= bus_rdata;
      end
    end
  end
endmodule

// File: rtl/spi_burst_slave_chk.sv
module spi_burst_slave_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic              spi_miso_oe,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack,
  input logic              frame_err,
  input logic              cmd_err
);
  a_r2_oe_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |=> !spi_miso_oe);

  a_r2_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_miso_oe |-> !spi_miso);

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> bus_req);

  a_r7_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  a_r8_no_bus_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !bus_req);

  a_r10_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
endmodule

bind spi_burst_slave spi_burst_slave_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .spi_miso_oe(spi_miso_oe), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .frame_err(frame_err), .cmd_err(cmd_err)
);

// File: tb/spi_burst_slave_tb_top.sv
module spi_burst_slave_tb_top;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic [7:0]  status_byte = 8'hA5;
  logic        bus_req, bus_we, bus_ack = 1'b0;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;
  logic        frame_err, cmd_err;

  int tests = 0, fails = 0, wr_cnt = 0, rd_cnt = 0, dly = 0;
  bit done = 0;
  logic [31:0] mem [16];
  logic [31:0] tx_words [8];
  logic [31:0] rx_words [8];
  logic [31:0] rx_hdr;
  logic        oe_seen;

  always #10 clk = ~clk;

  spi_burst_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .status_byte(status_byte), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .frame_err(frame_err), .cmd_err(cmd_err)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
        if (dly == 2) begin
          dly = 0;
          bus_ack = 1'b1;
          if (bus_we) begin
            mem[bus_addr[5:2]] = bus_wdata;
            wr_cnt++;
          end else begin
            bus_rdata = mem[bus_addr[5:2]];
            rd_cnt++;
          end
        end else dly++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    spi_cs_n = 1'b1;
    spi_sclk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] hdr, input int nbits);
    @(negedge clk);
    spi_cs_n = 1'b0;
    oe_seen = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      if (i < 32) b = hdr[31-i];
      else        b = tx_words[(i-32)/32][31-((i-32)%32)];
      spi_mosi = b;
      repeat (HALF) @(negedge clk);
      if (i == 0) oe_seen = spi_miso_oe;
      if (i < 32) rx_hdr[31-i] = spi_miso;
      else        rx_words[(i-32)/32][31-((i-32)%32)] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 miso_oe", {31'b0, spi_miso_oe}, 32'd0);
    chk("R1 miso", {31'b0, spi_miso}, 32'd0);
    chk("R1 bus_req", {31'b0, bus_req}, 32'd0);
    chk("R1 errors", {30'b0, frame_err, cmd_err}, 32'd0);
  endtask

  task automatic t_write_single();
    int w0 = wr_cnt;
    tx_words[0] = 32'hDEAD_BEEF;
    xfer({8'h61, 16'h0010, 8'd1}, 64);
    chk("R5 one write", wr_cnt - w0, 1);
    chk("R5 R7 word stored at 0x10", mem[4], 32'hDEAD_BEEF);
    chk("R4 status in header", rx_hdr, 32'hA500_0000);
    chk("R2 oe during frame", {31'b0, oe_seen}, 32'd1);
    chk("R2 oe off after frame", {31'b0, spi_miso_oe}, 32'd0);
    chk("R9 no frame error", {31'b0, frame_err}, 32'd0);
  endtask

  task automatic t_write_burst();
    int w0 = wr_cnt;
    tx_words[0] = 32'h1111_0001;
    tx_words[1] = 32'h2222_0002;
    tx_words[2] = 32'h3333_0003;
    xfer({8'h61, 16'h0020, 8'd3}, 128);
    chk("R5 three writes", wr_cnt - w0, 3);
    chk("R5 addr 0x20", mem[8], 32'h1111_0001);
    chk("R5 addr 0x24", mem[9], 32'h2222_0002);
    chk("R5 addr 0x28", mem[10], 32'h3333_0003);
  endtask

  task automatic t_read_burst();
    int r0 = rd_cnt;
    mem[12] = 32'hCAFE_F00D;
    mem[13] = 32'h8000_0001;
    xfer({8'h41, 16'h0030, 8'd2}, 96);
    chk("R6 read word 1", rx_words[0], 32'hCAFE_F00D);
    chk("R6 read word 2", rx_words[1], 32'h8000_0001);
    chk("R6 exactly two reads", rd_cnt - r0, 2);
    chk("R4 R3 status on read header", rx_hdr, 32'hA500_0000);
  endtask

  task automatic t_bad_opcode();
    int w0 = wr_cnt, r0 = rd_cnt;
    tx_words[0] = 32'hFFFF_FFFF;
    mem[2] = 32'h0BAD_0BAD;
    xfer({8'h55, 16'h0008, 8'd1}, 64);
    chk("R8 cmd_err on bad code", {31'b0, cmd_err}, 32'd1);
    chk("R8 no bus access", (wr_cnt - w0) + (rd_cnt - r0), 0);
    chk("R8 miso low", rx_words[0], 32'h0);
    chk("R8 memory untouched", mem[2], 32'h0BAD_0BAD);
  endtask

  task automatic t_zero_len();
    int w0 = wr_cnt;
    xfer({8'h61, 16'h0008, 8'd0}, 32);
    chk("R8 cmd_err on zero count", {31'b0, cmd_err}, 32'd1);
    chk("R8 zero count no write", wr_cnt - w0, 0);
    tx_words[0] = 32'h1234_5678;
    xfer({8'h61, 16'h0004, 8'd1}, 64);
    chk("R10 cmd_err cleared by new frame", {31'b0, cmd_err}, 32'd0);
    chk("R10 good frame after bad", mem[1], 32'h1234_5678);
  endtask

  task automatic t_short_frame();
    int w0;
    do_reset();
    w0 = wr_cnt;
    mem[15] = 32'h5555_5555;
    tx_words[0] = 32'hAAAA_0001;
    tx_words[1] = 32'hBBBB_0002;
    xfer({8'h61, 16'h0038, 8'd2}, 80);
    chk("R9 short frame flagged", {31'b0, frame_err}, 32'd1);
    chk("R9 only full word written", wr_cnt - w0, 1);
    chk("R9 partial word discarded", mem[15], 32'h5555_5555);
  endtask

  task automatic t_long_frame();
    int w0;
    do_reset();
    w0 = wr_cnt;
    mem[7] = 32'h7777_7777;
    tx_words[0] = 32'h0000_00A1;
    tx_words[1] = 32'h0000_00A2;
    xfer({8'h61, 16'h0018, 8'd1}, 96);
    chk("R9 long frame flagged", {31'b0, frame_err}, 32'd1);
    chk("R9 surplus word not written", wr_cnt - w0, 1);
    chk("R9 next address untouched", mem[7], 32'h7777_7777);
    tx_words[0] = 32'h0000_00B0;
    xfer({8'h61, 16'h0018, 8'd1}, 64);
    chk("R10 frame_err sticky", {31'b0, frame_err}, 32'd1);
  endtask

  task automatic t_header_cut();
    do_reset();
    xfer({8'h61, 16'h0000, 8'd1}, 16);
    chk("R9 cut command word", {31'b0, frame_err}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    do_reset();
    t_reset();
    t_write_single();
    t_write_burst();
    t_read_burst();
    t_bad_opcode();
    t_zero_len();
    t_short_frame();
    t_long_frame();
    t_header_cut();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("[TB] FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule